// File: doc/BRIEF.md
# Nibble ALU with Latched Condition Flags

This block is the arithmetic core of a small accumulator machine. It takes two 4-bit operands (`a_i`, the accumulator side, and `b_i`, the second register) and a 3-bit operation code. Combinationally it returns a result for the accumulator, together with a valid bit. The valid bit tells the surrounding datapath whether the accumulator should be written.

Three condition flags are stored in separately enabled flip-flops and sampled on an update strobe:
- a compare flag, written by the ordering and equality tests;
- a carry/borrow flag, written by addition and subtraction;
- a shift-out flag, written by the right shift.

Subtraction and both comparisons share one ripple adder, which is driven with the inverted second operand and a carry-in of one. Branch logic elsewhere reads the flags, and each flag keeps its value until its own operation runs again.

Top module: `nibble_alu`

## Requirements
- R1: Operation code 0 (add) gives `res_o` = (`a_i` + `b_i`) mod 16. When `upd_i` is high at a clock edge, `carry_o` takes the carry out of that 4-bit sum.
- R2: Operation code 1 (subtract) gives `res_o` = (`a_i` − `b_i`) mod 16. When strobed, `carry_o` becomes 1 exactly when `a_i` < `b_i` (borrow).
- R3: Operation code 2 (greater-than) sets `cmp_o`, when strobed, to 1 exactly when `b_i` > `a_i`.
- R4: Operation code 3 (equality) sets `cmp_o`, when strobed, to 1 exactly when `a_i` equals `b_i`.
- R5: Operation code 7 (shift right) gives `res_o` = {`b_i`[0], `a_i`[3:1]}. When strobed, `shout_o` takes the old `a_i`[0].
- R6: Operation codes 4, 5 and 6 give `a_i` & `b_i`, `a_i` | `b_i` and ~`a_i` respectively.
- R7: `cmp_o` changes only on codes 2 and 3, `carry_o` only on codes 0 and 1, and `shout_o` only on code 7. Every other operation leaves each flag at its held value, even with the strobe high.
- R8: For codes 2 and 3, `res_vld_o` is 0 and `res_o` equals `a_i`, so the accumulator is unchanged. For every other code, `res_vld_o` is 1.
- R9: With `upd_i` low, no flag changes at a clock edge.
- R10: Asserting `rst_ni` low clears all three flags asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 gt, 3 eq, 4 and, 5 or, 6 not, 7 shr) |
| a_i | input | 4 | Accumulator operand |
| b_i | input | 4 | Second operand |
| upd_i | input | 1 | Flag update strobe |
| res_o | output | 4 | Combinational result for the accumulator |
| res_vld_o | output | 1 | Accumulator write enable |
| cmp_o | output | 1 | Compare flag |
| carry_o | output | 1 | Carry/borrow flag |
| shout_o | output | 1 | Shift-out flag |

## Verification
The hardest case to reach is a flag that must survive other operations while the strobe stays high. This is only observable when the flag was left at 1 and neighbouring operations would have produced a different value.

The stimulus walks every operation code in turn over all 256 operand pairs, with the strobe high on most cycles. Each flag is therefore set by its own operation and then carried through the whole sweeps of the other operations. The strobe drops on a fixed subset of operand pairs, which also covers the hold-without-strobe case inside each sweep. The reference model tracks the held flags from one cycle to the next and compares them on every clock.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_GT  = 3'd2,
    OP_EQ  = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_NOT = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   cy;
  logic [W-1:0] b_x;

  assign cy[0] = sub_i;  // +1 completes the two's complement

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign b_x[gi]   = b_i[gi] ^ sub_i;
    assign sum_o[gi] = a_i[gi] ^ b_x[gi] ^ cy[gi];
    assign cy[gi+1]  = (a_i[gi] & b_x[gi]) | (cy[gi] & (a_i[gi] ^ b_x[gi]));
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    upd_i,
  input  alu_op_e op_i,
  input  logic    cout_i,
  input  logic    zero_i,
  input  logic    shout_i,
  output logic    cmp_o,
  output logic    carry_o,
  output logic    shout_o
);
  logic cmp_q, carry_q, shout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= 1'b0;
      carry_q <= 1'b0;
      shout_q <= 1'b0;
    end else if (upd_i) begin
      case (op_i)
        OP_ADD:  carry_q <= cout_i;
        OP_SUB:  carry_q <= ~cout_i;   // no carry out means borrow
        OP_GT:   cmp_q   <= ~cout_i;   // A-B borrows iff B > A
        OP_EQ:   cmp_q   <= zero_i;
        OP_SHR:  shout_q <= shout_i;
        default: ;
      endcase
    end
  end

  assign cmp_o   = cmp_q;
  assign carry_o = carry_q;
  assign shout_o = shout_q;

  a_r9_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable({cmp_q, carry_q, shout_q}));

  a_r7_cmp_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_GT && op_i != OP_EQ) |=> $stable(cmp_q));

  a_r7_carry_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_ADD && op_i != OP_SUB) |=> $stable(carry_q));

  a_r7_shout_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_SHR) |=> $stable(shout_q));
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         upd_i,
  output logic [W-1:0] res_o,
  output logic         res_vld_o,
  output logic         cmp_o,
  output logic         carry_o,
  output logic         shout_o
);
  localparam int MAXV = (1 << W) - 1;

  alu_op_e      op;
  logic         sub_sel;
  logic [W-1:0] sum;
  logic         cout;

  assign op      = alu_op_e'(op_i);
  assign sub_sel = (op != OP_ADD);  // sub, gt, eq share the subtractor

  alu_addsub #(.W(W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_sel),
    .sum_o  (sum),
    .cout_o (cout)
  );

  alu_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd_i),
    .op_i    (op),
    .cout_i  (cout),
    .zero_i  (~|sum),
    .shout_i (a_i[0]),
    .cmp_o   (cmp_o),
    .carry_o (carry_o),
    .shout_o (shout_o)
  );

  always_comb begin
    res_vld_o = 1'b1;
    case (op)
      OP_ADD, OP_SUB: res_o = sum;
      OP_AND:         res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_NOT:         res_o = ~a_i;
      OP_SHR:         res_o = {b_i[0], a_i[W-1:1]};
      default: begin  // compares: accumulator kept
        res_o     = a_i;
        res_vld_o = 1'b0;
      end
    endcase
  end

  a_r1_add_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op == OP_ADD) |=>
      carry_o == ((int'($past(a_i)) + int'($past(b_i))) > MAXV));

  a_r2_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op == OP_SUB) |=> carry_o == ($past(a_i) < $past(b_i)));

  a_r3_gt_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op == OP_GT) |=> cmp_o == ($past(b_i) > $past(a_i)));

  a_r4_eq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op == OP_EQ) |=> cmp_o == ($past(a_i) == $past(b_i)));

  a_r5_shift_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op == OP_SHR) |=> shout_o == $past(a_i[0]));

  a_r8_acc_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> (res_o == a_i && (op == OP_GT || op == OP_EQ)));
endmodule

// File: tb/nibble_alu_tb.sv
`timescale 1ns/1ps
module nibble_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [3:0] a = 4'd0, b = 4'd0;
  logic       upd = 1'b0;
  logic [3:0] res;
  logic       res_vld, cmp, carry, shout;

  int n_chk = 0, n_fail = 0;
  int m_cmp = 0, m_carry = 0, m_shout = 0;
  string flag_tag = "R10";

  always #2 clk = ~clk;  // 250 MHz

  nibble_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b), .upd_i(upd),
    .res_o(res), .res_vld_o(res_vld), .cmp_o(cmp), .carry_o(carry), .shout_o(shout)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d act=%0d exp=%0d", rq, op, a, b, act, exp);
    end
  endtask

  task automatic chk_flags();
    chk(flag_tag, int'(cmp), m_cmp);
    chk(flag_tag, int'(carry), m_carry);
    chk(flag_tag, int'(shout), m_shout);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ea, eb, er, ev;
    string rtag;
    #5;
    chk_flags();  // R10 flags clear under reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          @(negedge clk);
          chk_flags();
          op = 3'(o); a = 4'(ia); b = 4'(ib);
          upd = (((ia * 3 + ib) % 5) != 0);
          #1;
          ea = ia; eb = ib; ev = 1;
          case (o)
            0: begin er = (ea + eb) % 16; rtag = "R1"; end
            1: begin er = (ea - eb + 16) % 16; rtag = "R2"; end
            2: begin er = ea; ev = 0; rtag = "R3"; end
            3: begin er = ea; ev = 0; rtag = "R4"; end
            4: begin er = ea & eb; rtag = "R6"; end
            5: begin er = ea | eb; rtag = "R6"; end
            6: begin er = 15 - ea; rtag = "R6"; end
            default: begin er = (eb % 2) * 8 + ea / 2; rtag = "R5"; end
          endcase
          chk(rtag, int'(res), er);
          chk("R8", int'(res_vld), ev);
          if (upd) begin
            flag_tag = (o == 4 || o == 5 || o == 6) ? "R7" : rtag;
            case (o)
              0: m_carry = (ea + eb > 15) ? 1 : 0;
              1: m_carry = (ea < eb) ? 1 : 0;
              2: m_cmp   = (eb > ea) ? 1 : 0;
              3: m_cmp   = (ea == eb) ? 1 : 0;
              7: m_shout = ea % 2;
              default: ;
            endcase
          end else begin
            flag_tag = "R9";
          end
        end
      end
    end
    @(negedge clk);
    chk_flags();
    // leave all flags set, then reset asynchronously
    op = 3'd2; a = 4'd0; b = 4'd5; upd = 1'b1;
    @(negedge clk);
    op = 3'd7; a = 4'd1;
    @(negedge clk);
    op = 3'd1; a = 4'd0; b = 4'd1;
    @(negedge clk);
    upd = 1'b0;
    flag_tag = "R7";
    m_cmp = 1; m_carry = 1; m_shout = 1;
    chk_flags();
    #0.5 rst_n = 1'b0;
    #0.5;
    flag_tag = "R10";
    m_cmp = 0; m_carry = 0; m_shout = 0;
    chk_flags();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule